// File: doc/BRIEF.md
# Shared Interrupt Conditioner and Router

This block takes a bank of external interrupt inputs that several cores share. It conditions each input and delivers it to exactly one core. Every input passes through a two-flop synchronizer. It is then qualified by three per-interrupt bits: active-low polarity, edge trigger and dual-edge. The result is a pending bit. In level mode the pending bit follows the conditioned input. In edge mode it is latched until software clears it.

Enables change only through a write-one-to-set address and a write-one-to-clear address. A software edge word sets or clears the latched pending bit of one interrupt. Software uses it both to raise inter-core interrupts and to acknowledge edges.

Each interrupt carries two more registers:
- a target-core field;
- a pin-map register with a valid bit.

Each core receives a vector of its pending, enabled and routed interrupts, plus one interrupt line that is the OR of that vector.

Configuration uses a word-addressed register bus. Writes take effect at the clock edge and reads are combinational. Word addresses used below:
- 0x000: config word.
- 0x001: software edge word.
- 0x008+w: polarity.
- 0x010+w: trigger.
- 0x018+w: dual-edge.
- 0x020+w: enable readback.
- 0x028+w: enable set.
- 0x030+w: enable clear.
- 0x038+w: pending.
- 0x100+i: target core.
- 0x200+i: pin map.

Here w is the 32-interrupt word index and interrupt i sits at bit i%32.

Top module: `shirq_router`

## Requirements
- R1: After reset every polarity, trigger, dual-edge, enable, target-core and pin-map register reads 0. That means positive polarity, level trigger, disabled, core 0, map invalid. All core outputs are low.
- R2: Word 0x000 reads NUM_IRQ/8-1 in bits [7:0] and NUM_CORE-1 in bits [15:8], with all other bits 0. The defaults give 0x0000_0303.
- R3: At word 0x028+w, a 1 in a bit enables that interrupt. At 0x030+w, a 1 disables it. Bits written 0 leave their state unchanged. Word 0x020+w reads the enables back. The set, clear and software edge words read 0.
- R4: In level mode (trigger bit 0), pending equals the input XOR the polarity bit, where polarity 1 means active low. It reflects the input value from two clocks earlier and reads at word 0x038+w.
- R5: In edge mode (trigger bit 1, dual 0), a rising input with polarity 0, or a falling input with polarity 1, sets pending three clocks after the input change. Pending stays set until it is cleared. While in level mode the latched state is held clear.
- R6: In edge mode with the dual bit 1, both input transitions set pending and polarity has no effect. In level mode the dual bit has no effect.
- R7: A write to word 0x001 selects the interrupt in bits [7:0]. Bit 31 = 1 sets its latched pending bit and bit 31 = 0 clears it. This acts only in edge mode. An index of NUM_IRQ or more has no effect. A hardware edge arriving in the same cycle as a clear wins.
- R8: Word 0x100+i holds the target core in its low bits. Bit i of core c's vector is pending AND enabled AND map-valid AND target equals c. core_irq_o[c] is the OR of that vector.
- R9: Word 0x200+i holds the map valid bit in bit 31 and the pin number in bits [PIN_W-1:0], and both read back. An interrupt whose valid bit is 0 reaches no core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 10 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_i | input | NUM_IRQ | Asynchronous interrupt inputs |
| pend_vec_o | output | NUM_CORE*NUM_IRQ | Per-core vector; core c at bits [c*NUM_IRQ +: NUM_IRQ] |
| core_irq_o | output | NUM_CORE | One interrupt line per core |

## Verification
The bench targets the following corner cases:
- Synchronizer latency. A design with one flop too few or too many would move level pending by a cycle against the model.
- Active-low levels that assert straight out of reset, and the falling-edge case. An inverted polarity path would assert the wrong interrupts.
- Dual-edge with polarity set to 1. A design that let polarity leak into dual mode would miss one transition.
- A software set that hits a level-mode interrupt, and an out-of-range index. Either would raise a spurious line if decoded wrongly.
- Moving a live interrupt between cores and invalidating its map. Both would show the interrupt on two cores, or on a stale core.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  typedef logic [9:0] addr_t;

  localparam addr_t A_CFG   = 10'h000;
  localparam addr_t A_SWE   = 10'h001;
  localparam addr_t A_POL   = 10'h008;
  localparam addr_t A_TRIG  = 10'h010;
  localparam addr_t A_DUAL  = 10'h018;
  localparam addr_t A_MASK  = 10'h020;
  localparam addr_t A_SMASK = 10'h028;
  localparam addr_t A_RMASK = 10'h030;
  localparam addr_t A_PEND  = 10'h038;
  localparam addr_t A_ROUTE = 10'h100;
  localparam addr_t A_MAP   = 10'h200;

  localparam int unsigned SWE_SET_BIT = 31;
  localparam int unsigned MAP_VLD_BIT = 31;
endpackage

// File: rtl/shirq_cond.sv
module shirq_cond #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] pol_i,
  input  logic [NUM_IRQ-1:0] trig_i,
  input  logic [NUM_IRQ-1:0] dual_i,
  input  logic [NUM_IRQ-1:0] sw_set_i,
  input  logic [NUM_IRQ-1:0] sw_clr_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] s1_q, s2_q, prev_q, edge_q;
  logic [NUM_IRQ-1:0] rise, fall, ev, edge_d;

  assign rise   = s2_q & ~prev_q;
  assign fall   = ~s2_q & prev_q;
  // dual-edge overrides polarity
  assign ev     = (dual_i & (rise | fall)) | (~dual_i & ~pol_i & rise) | (~dual_i & pol_i & fall);
  assign edge_d = trig_i & (ev | sw_set_i | (edge_q & ~sw_clr_i));
  assign pend_o = (trig_i & edge_q) | (~trig_i & (s2_q ^ pol_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      s1_q   <= irq_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      edge_q <= edge_d;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    p_level_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trig_i[i] |=> !edge_q[i]);
    p_sw_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[i] && sw_clr_i[i] && !ev[i] && !sw_set_i[i]) |=> !edge_q[i]);
    p_dual_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[i] && dual_i[i] && (s2_q[i] != prev_q[i])) |=> edge_q[i]);
  end
endmodule

// File: rtl/shirq_regs.sv
module shirq_regs
  import shirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 32,
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned PIN_W    = 6,
  parameter int unsigned CORE_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  addr_t                     addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_IRQ-1:0]        pend_i,
  output logic [NUM_IRQ-1:0]        pol_o,
  output logic [NUM_IRQ-1:0]        trig_o,
  output logic [NUM_IRQ-1:0]        dual_o,
  output logic [NUM_IRQ-1:0]        mask_o,
  output logic [NUM_IRQ-1:0]        valid_o,
  output logic [NUM_IRQ*CORE_W-1:0] route_o,
  output logic [NUM_IRQ-1:0]        sw_set_o,
  output logic [NUM_IRQ-1:0]        sw_clr_o
);
  localparam int unsigned NW = (NUM_IRQ + 31) / 32;
  localparam int unsigned W0 = (NUM_IRQ < 32) ? NUM_IRQ : 32;

  logic [NUM_IRQ-1:0] pol_q, trig_q, dual_q, mask_q, valid_q;
  logic [CORE_W-1:0]  route_q [NUM_IRQ];
  logic [PIN_W-1:0]   pin_q   [NUM_IRQ];
  logic [NW*32-1:0]   pol_w, trig_w, dual_w, mask_w, pend_w;
  logic               sw_hit;

  assign sw_hit = we_i && (addr_i == A_SWE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      valid_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        route_q[i] <= '0;
        pin_q[i]   <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (addr_i == A_POL  + addr_t'(i / 32)) pol_q[i]  <= wdata_i[i % 32];
        if (addr_i == A_TRIG + addr_t'(i / 32)) trig_q[i] <= wdata_i[i % 32];
        if (addr_i == A_DUAL + addr_t'(i / 32)) dual_q[i] <= wdata_i[i % 32];
        if (addr_i == A_SMASK + addr_t'(i / 32) && wdata_i[i % 32]) mask_q[i] <= 1'b1;
        if (addr_i == A_RMASK + addr_t'(i / 32) && wdata_i[i % 32]) mask_q[i] <= 1'b0;
        if (addr_i == A_ROUTE + addr_t'(i)) route_q[i] <= wdata_i[CORE_W-1:0];
        if (addr_i == A_MAP + addr_t'(i)) begin
          valid_q[i] <= wdata_i[MAP_VLD_BIT];
          pin_q[i]   <= wdata_i[PIN_W-1:0];
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_out
    assign sw_set_o[i] = sw_hit &&  wdata_i[SWE_SET_BIT] && (wdata_i[7:0] == 8'(i));
    assign sw_clr_o[i] = sw_hit && !wdata_i[SWE_SET_BIT] && (wdata_i[7:0] == 8'(i));
    assign route_o[i*CORE_W +: CORE_W] = route_q[i];
  end

  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign dual_o  = dual_q;
  assign mask_o  = mask_q;
  assign valid_o = valid_q;

  always_comb begin
    pol_w  = '0; pol_w[NUM_IRQ-1:0]  = pol_q;
    trig_w = '0; trig_w[NUM_IRQ-1:0] = trig_q;
    dual_w = '0; dual_w[NUM_IRQ-1:0] = dual_q;
    mask_w = '0; mask_w[NUM_IRQ-1:0] = mask_q;
    pend_w = '0; pend_w[NUM_IRQ-1:0] = pend_i;
    rdata_o = '0;
    if (addr_i == A_CFG) begin
      rdata_o[7:0]  = 8'(NUM_IRQ / 8 - 1);
      rdata_o[15:8] = 8'(NUM_CORE - 1);
    end
    for (int w = 0; w < NW; w++) begin
      if (addr_i == A_POL  + addr_t'(w)) rdata_o = pol_w[w*32 +: 32];
      if (addr_i == A_TRIG + addr_t'(w)) rdata_o = trig_w[w*32 +: 32];
      if (addr_i == A_DUAL + addr_t'(w)) rdata_o = dual_w[w*32 +: 32];
      if (addr_i == A_MASK + addr_t'(w)) rdata_o = mask_w[w*32 +: 32];
      if (addr_i == A_PEND + addr_t'(w)) rdata_o = pend_w[w*32 +: 32];
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (addr_i == A_ROUTE + addr_t'(i)) rdata_o[CORE_W-1:0] = route_q[i];
      if (addr_i == A_MAP + addr_t'(i)) begin
        rdata_o[MAP_VLD_BIT] = valid_q[i];
        rdata_o[PIN_W-1:0]   = pin_q[i];
      end
    end
  end

  p_mask_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SMASK) |=>
      ((mask_q[W0-1:0] & $past(wdata_i[W0-1:0])) == $past(wdata_i[W0-1:0])));
  p_mask_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_RMASK) |=> ((mask_q[W0-1:0] & $past(wdata_i[W0-1:0])) == '0));
endmodule

// File: rtl/shirq_route.sv
module shirq_route #(
  parameter int unsigned NUM_IRQ  = 32,
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned CORE_W   = 2
) (
  input  logic [NUM_IRQ-1:0]          pend_i,
  input  logic [NUM_IRQ-1:0]          mask_i,
  input  logic [NUM_IRQ-1:0]          valid_i,
  input  logic [NUM_IRQ*CORE_W-1:0]   route_i,
  output logic [NUM_CORE*NUM_IRQ-1:0] pend_vec_o,
  output logic [NUM_CORE-1:0]         core_irq_o
);
  logic [NUM_IRQ-1:0] live;
  assign live = pend_i & mask_i & valid_i;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign pend_vec_o[c*NUM_IRQ + i] = live[i] && (route_i[i*CORE_W +: CORE_W] == CORE_W'(c));
    end
    assign core_irq_o[c] = |pend_vec_o[c*NUM_IRQ +: NUM_IRQ];
  end
endmodule

// File: rtl/shirq_router.sv
module shirq_router
  import shirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 32,
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned PIN_W    = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [9:0]                  bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  input  logic [NUM_IRQ-1:0]          irq_i,
  output logic [NUM_CORE*NUM_IRQ-1:0] pend_vec_o,
  output logic [NUM_CORE-1:0]         core_irq_o
);
  localparam int unsigned CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;

  logic [NUM_IRQ-1:0]        pol, trig, dual, mask, valid, sw_set, sw_clr, pend;
  logic [NUM_IRQ*CORE_W-1:0] route;

  shirq_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W), .CORE_W(CORE_W)) u_regs (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .pend_i(pend), .pol_o(pol), .trig_o(trig), .dual_o(dual),
    .mask_o(mask), .valid_o(valid), .route_o(route), .sw_set_o(sw_set), .sw_clr_o(sw_clr)
  );

  shirq_cond #(.NUM_IRQ(NUM_IRQ)) u_cond (
    .clk_i, .rst_ni, .irq_i, .pol_i(pol), .trig_i(trig), .dual_i(dual),
    .sw_set_i(sw_set), .sw_clr_i(sw_clr), .pend_o(pend)
  );

  shirq_route #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) u_route (
    .pend_i(pend), .mask_i(mask), .valid_i(valid), .route_i(route),
    .pend_vec_o, .core_irq_o
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
    p_route_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[i] && mask[i] && valid[i] && (32'(route[i*CORE_W +: CORE_W]) < NUM_CORE))
        |-> core_irq_o[route[i*CORE_W +: CORE_W]]);
    p_masked_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mask[i] && valid[i]) |-> !core_irq_o[0] || (|(pend_vec_o[NUM_IRQ-1:0] & ~(1 << i))) ||
        !pend_vec_o[i]);
  end
endmodule

// File: tb/shirq_router_test.sv
`timescale 1ns/1ps
module shirq_router_test;
  localparam int N = 32;
  localparam int C = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq = '0;
  logic [C*N-1:0] pvec;
  logic [C-1:0]  cirq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [31:0] m_s1, m_s2, m_prev, m_edge, m_pol, m_trig, m_dual, m_mask, m_valid;
  int m_route [N];
  int m_pin [N];

  shirq_router #(.NUM_IRQ(N), .NUM_CORE(C), .PIN_W(6)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_i(irq), .pend_vec_o(pvec), .core_irq_o(cirq)
  );

  always #10 clk = ~clk;

  function automatic bit [31:0] m_pend();
    bit [31:0] p;
    for (int i = 0; i < N; i++) p[i] = m_trig[i] ? m_edge[i] : (m_s2[i] ^ m_pol[i]);
    return p;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_edge = 0; m_pol = 0; m_trig = 0;
    m_dual = 0; m_mask = 0; m_valid = 0;
    for (int i = 0; i < N; i++) begin m_route[i] = 0; m_pin[i] = 0; end
  endtask

  task automatic model_step();
    bit [31:0] ne;
    for (int i = 0; i < N; i++) begin
      bit r, f, ev, ss, sc;
      r  = m_s2[i] && !m_prev[i];
      f  = !m_s2[i] && m_prev[i];
      ev = m_dual[i] ? (r || f) : (m_pol[i] ? f : r);
      ss = we && addr == 10'h001 && wdata[7:0] == i && wdata[31];
      sc = we && addr == 10'h001 && wdata[7:0] == i && !wdata[31];
      ne[i] = m_trig[i] && (ev || ss || (m_edge[i] && !sc));
    end
    m_edge = ne;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
    if (we) begin
      if (addr == 10'h008) m_pol  = wdata;
      if (addr == 10'h010) m_trig = wdata;
      if (addr == 10'h018) m_dual = wdata;
      if (addr == 10'h028) m_mask = m_mask | wdata;
      if (addr == 10'h030) m_mask = m_mask & ~wdata;
      if (addr >= 10'h100 && addr < 10'h100 + N) m_route[addr - 10'h100] = int'(wdata[1:0]);
      if (addr >= 10'h200 && addr < 10'h200 + N) begin
        m_valid[addr - 10'h200] = wdata[31];
        m_pin[addr - 10'h200]   = int'(wdata[5:0]);
      end
    end
  endtask

  task automatic compare();
    bit [31:0] p;
    p = m_pend();
    for (int c = 0; c < C; c++) begin
      bit [31:0] e;
      for (int i = 0; i < N; i++) e[i] = p[i] && m_mask[i] && m_valid[i] && m_route[i] == c;
      checks++;
      if (pvec[c*N +: N] !== e) begin
        errors++;
        $display("FAIL R8 core %0d vector: got %h expected %h", c, pvec[c*N +: N], e);
      end
      checks++;
      if (cirq[c] !== (|e)) begin
        errors++;
        $display("FAIL R8 core %0d line: got %b expected %b", c, cirq[c], |e);
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cycle();
    we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    // R1 reset state
    rd(10'h008, 0, "R1"); rd(10'h010, 0, "R1"); rd(10'h018, 0, "R1");
    rd(10'h020, 0, "R1"); rd(10'h105, 0, "R1"); rd(10'h205, 0, "R1");
    rd(10'h038, 0, "R1");
    // R2 config
    rd(10'h000, 32'h0000_0303, "R2");
    // R9 map all valid, pin = index
    for (int i = 0; i < N; i++) wr(10'h200 + 10'(i), 32'h8000_0000 | i);
    rd(10'h213, 32'h8000_0013, "R9");
    // R3 mask set / clear
    wr(10'h028, 32'hF0F0_00FF);
    wr(10'h030, 32'h0000_000F);
    rd(10'h020, 32'hF0F0_00F0, "R3");
    rd(10'h028, 0, "R3"); rd(10'h030, 0, "R3"); rd(10'h001, 0, "R3");
    wr(10'h028, 32'h00FF_0000);
    rd(10'h020, 32'hF0FF_00F0, "R3");
    // R4 level, active high and active low
    wr(10'h104, 32'd2);
    irq[4] = 1'b1;
    cycle();
    rd(10'h038, m_pend(), "R4");
    cycle();
    rd(10'h038, m_pend(), "R4");
    checks++;
    if (!cirq[2]) begin errors++; $display("FAIL R4 level line: got 0 expected 1"); end
    wr(10'h008, 32'h0000_0020);
    idle(3);
    rd(10'h038, 32'h0000_0030, "R4");
    irq[4] = 1'b0;
    idle(3);
    rd(10'h038, 32'h0000_0020, "R4");
    // R5 edge rising on 6, falling on 5
    wr(10'h010, 32'h0000_0060);
    irq[6] = 1'b1; cycle(); irq[6] = 1'b0;
    idle(4);
    rd(10'h038, 32'h0000_0040, "R5");
    irq[5] = 1'b1; idle(4); irq[5] = 1'b0; idle(4);
    rd(10'h038, 32'h0000_0060, "R5");
    wr(10'h001, 32'd6); wr(10'h001, 32'd5);
    rd(10'h038, 32'h0000_0000, "R7");
    // R6 dual edge with polarity set
    wr(10'h008, 32'h0000_00A0);
    wr(10'h010, 32'h0000_0080);
    wr(10'h018, 32'h0000_0088);
    irq[7] = 1'b1; idle(4);
    rd(10'h038, m_pend(), "R6");
    wr(10'h001, 32'd7); idle(1);
    irq[7] = 1'b0; idle(4);
    rd(10'h038, m_pend(), "R6");
    irq[3] = 1'b1; idle(3);
    rd(10'h038, m_pend(), "R6");
    irq[3] = 1'b0;
    wr(10'h001, 32'd7);
    // R7 software set/clear, out-of-range and level mode
    wr(10'h114, 32'd3);
    wr(10'h010, 32'h0010_0000);
    wr(10'h001, 32'h8000_0014);
    rd(10'h038, m_pend(), "R7");
    checks++;
    if (!cirq[3]) begin errors++; $display("FAIL R7 set line: got 0 expected 1"); end
    wr(10'h001, 32'h8000_0028);
    rd(10'h038, m_pend(), "R7");
    wr(10'h001, 32'h8000_0011);
    rd(10'h038, m_pend(), "R7");
    wr(10'h001, 32'h0000_0014);
    rd(10'h038, m_pend(), "R7");
    checks++;
    if (cirq[3]) begin errors++; $display("FAIL R7 clear line: got 1 expected 0"); end
    // R8 reroute live level interrupt 16
    irq[16] = 1'b1; idle(3);
    wr(10'h110, 32'd1); idle(2);
    wr(10'h110, 32'd3); idle(2);
    rd(10'h110, 32'd3, "R8");
    // R9 invalid map blocks delivery
    wr(10'h210, 32'h0000_0007); idle(2);
    rd(10'h210, 32'h0000_0007, "R9");
    checks++;
    if (cirq[3]) begin errors++; $display("FAIL R9 invalid map: got 1 expected 0"); end
    irq = '1; idle(5);
    irq = '0; idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule